// File: doc/BRIEF.md
# Error Counter Status Indicator

This block sits behind a bit-pattern checker. Each cycle the checker reports two numbers: how many bits it compared and how many of those were wrong. The block adds both numbers into saturating totals, so a bit error rate can be formed from the pair. It also turns the error total into indications a person can read on a board.

There are four indications. A timed error flag stays lit for a fixed hold window after any error, and each new error restarts that window. Three sticky range lamps record how far the error total has climbed. A push button, held down, switches the two-digit display byte from its normal source to the leading byte of the error total. Driving the segments themselves belongs to the next stage, so the block only provides the byte and a flag that says the byte is the count.

Two inputs clear the block: a clear-counter input and a pattern/checker reset. Either one returns the totals, the lamps and the flag to zero.

Top module: `errstat_indicator`

## Requirements
- R1: On every cycle without a clear, `err_count` increases by `err_inc` (an unsigned count of errored bits for that cycle). The output shows the new total one clock edge after the increment is presented.
- R2: `err_count` saturates at all ones (0xFFFFFF by default) and never wraps.
- R3: `chk_count` accumulates `chk_inc` in the same way as R1, and saturates at all ones of its own width.
- R4: After any cycle with nonzero `err_inc`, `err_flag` is high from the next edge onward. It stays high for HOLD_CYC cycles counted from the last such cycle, so each new error restarts the window.
- R5: Lamp `range_led[k]` lights on the edge at which `err_count` first reaches 0xFF·2^(8k). That is the first value at which the byte field [8k+7:8k] reads 0xFF. Bit 0 covers bits [7:0], bit 1 covers [15:8] and bit 2 covers [23:16].
- R6: A lit range lamp stays lit until a clear, even if its byte field later rolls past 0xFF.
- R7: While `clr_cnt` or `pat_rst` is high, the next edge zeroes `err_count`, `chk_count`, `range_led` and `err_flag`. The clear wins over any increment presented in the same cycle.
- R8: While the filtered show button is held, `disp_is_cnt` is 1 and `disp_val` is the most significant nonzero byte of `err_count`, or 0x00 when the count is zero. For example, a count of 0x0002FF shows 0x02.
- R9: While the filtered button is released, `disp_is_cnt` is 0 and `disp_val` equals `disp_norm`.
- R10: `show_btn_raw` passes through two synchronizer stages and a debouncer. The filtered level follows the raw level only after the synchronized level has differed from the filtered level for DEB_CYC consecutive cycles. A pulse shorter than DEB_CYC cycles has no effect.
- R11: While `rst_n` is low, all counts, lamps, the flag and `disp_is_cnt` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_inc | input | INC_W | Errored bits reported this cycle |
| chk_inc | input | INC_W | Checked bits reported this cycle |
| clr_cnt | input | 1 | Clear counts, lamps and flag |
| pat_rst | input | 1 | Pattern/checker reset, with the same clearing effect as `clr_cnt` |
| show_btn_raw | input | 1 | Raw show-count push button, active high |
| disp_norm | input | 8 | Display byte used when the button is released |
| err_flag | output | 1 | Timed error indication |
| range_led | output | CNT_W/8 | Sticky byte-range lamps |
| disp_val | output | 8 | Byte for the display stage |
| disp_is_cnt | output | 1 | High when `disp_val` carries the count |
| err_count | output | CNT_W | Saturating errored-bit total |
| chk_count | output | CHK_W | Saturating checked-bit total |

## Verification
The bench drives the error total one step at a time across 0xFE→0xFF. A lamp compare that is off by one, or that tests a single field with equality instead of a threshold, would light a cycle early or late. Large increments then push the total past 0xFFFFFF. A counter that wraps would fall back near zero and would clear the upper-field lamps if they were not sticky. A clear is presented in the same cycle as an error, so a design that lets the increment win would leave a count of 5 and a lit flag. A three-cycle button glitch checks the debouncer, and a filter that passes short pulses would briefly switch the display to the count. The value 0x2FF with the button held checks that the leading-byte selection returns 0x02 and not the low byte 0xFF.

// File: rtl/errstat_pkg.sv
package errstat_pkg;

  localparam int FIELD_W = 8;

  // Leading nonzero byte of v, looking at the lowest nbytes bytes.
  function automatic logic [7:0] lead_byte(input logic [63:0] v, input int nbytes);
    logic [7:0] r;
    r = 8'h00;
    for (int i = 0; i < 8; i++) begin
      if (i < nbytes && v[i*FIELD_W +: FIELD_W] != 8'h00)
        r = v[i*FIELD_W +: FIELD_W];
    end
    return r;
  endfunction

  // First count value at which byte field idx reads all ones.
  function automatic logic [63:0] field_floor(input int idx);
    return 64'hFF << (FIELD_W * idx);
  endfunction

endpackage

// File: rtl/errstat_sat_acc.sv
module errstat_sat_acc #(
  parameter int W  = 24,
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [IW-1:0] inc,
  output logic [W-1:0]  cnt,
  output logic [W-1:0]  cnt_nxt
);

  logic [W:0] sum;
  logic       carry_out;

  always_comb begin
    sum       = {1'b0, cnt} + {{(W + 1 - IW){1'b0}}, inc};
    carry_out = sum[W];
    if (clr)            cnt_nxt = '0;
    else if (carry_out) cnt_nxt = '1;
    else                cnt_nxt = sum[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

  a_r2_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '1 && !clr) |=> cnt == '1);

  a_r1_never_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr) |=> cnt >= $past(cnt));

  a_r7_acc_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0);

endmodule

// File: rtl/errstat_hold_timer.sv
module errstat_hold_timer #(
  parameter int HOLD_CYC = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic hit,
  output logic flag
);

  localparam int TW = $clog2(HOLD_CYC + 1);

  logic [TW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           left <= '0;
    else if (clr)         left <= '0;
    else if (hit)         left <= TW'(HOLD_CYC);
    else if (left != '0)  left <= left - 1'b1;
  end

  assign flag = (left != '0);

  a_r4_hit_lights: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !clr) |=> flag);

  a_r4_no_early_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr && !hit && left != 1) |=> flag);

  a_r7_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !flag);

endmodule

// File: rtl/errstat_btn_filter.sv
module errstat_btn_filter #(
  parameter int DEB_CYC = 500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic level
);

  localparam int DW = $clog2(DEB_CYC + 1);

  logic          sync_a;
  logic          sync_b;
  logic [DW-1:0] run;
  logic          differs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= 1'b0;
      sync_b <= 1'b0;
    end else begin
      sync_a <= raw;
      sync_b <= sync_a;
    end
  end

  assign differs = (sync_b != level);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= 1'b0;
      run   <= '0;
    end else if (!differs) begin
      run <= '0;
    end else if (run == DW'(DEB_CYC - 1)) begin
      level <= sync_b;
      run   <= '0;
    end else begin
      run <= run + 1'b1;
    end
  end

  a_r10_quiet_when_equal: assert property (@(posedge clk) disable iff (!rst_n)
    (!differs) |=> $stable(level));

  a_r10_needs_full_run: assert property (@(posedge clk) disable iff (!rst_n)
    (differs && run != DW'(DEB_CYC - 1)) |=> $stable(level));

endmodule

// File: rtl/errstat_indicator.sv
module errstat_indicator
  import errstat_pkg::*;
#(
  parameter int CNT_W    = 24,
  parameter int CHK_W    = 40,
  parameter int INC_W    = 8,
  parameter int HOLD_CYC = 50_000_000,
  parameter int DEB_CYC  = 500_000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [INC_W-1:0]          err_inc,
  input  logic [INC_W-1:0]          chk_inc,
  input  logic                      clr_cnt,
  input  logic                      pat_rst,
  input  logic                      show_btn_raw,
  input  logic [7:0]                disp_norm,
  output logic                      err_flag,
  output logic [CNT_W/FIELD_W-1:0]  range_led,
  output logic [7:0]                disp_val,
  output logic                      disp_is_cnt,
  output logic [CNT_W-1:0]          err_count,
  output logic [CHK_W-1:0]          chk_count
);

  localparam int NF = CNT_W / FIELD_W;

  logic             clr_any;
  logic             err_hit;
  logic [CNT_W-1:0] err_nxt;
  logic [CHK_W-1:0] chk_nxt;
  logic             show_held;

  assign clr_any = clr_cnt | pat_rst;
  assign err_hit = |err_inc;

  errstat_sat_acc #(.W(CNT_W), .IW(INC_W)) u_err_acc (
    .clk(clk), .rst_n(rst_n), .clr(clr_any), .inc(err_inc),
    .cnt(err_count), .cnt_nxt(err_nxt)
  );

  errstat_sat_acc #(.W(CHK_W), .IW(INC_W)) u_chk_acc (
    .clk(clk), .rst_n(rst_n), .clr(clr_any), .inc(chk_inc),
    .cnt(chk_count), .cnt_nxt(chk_nxt)
  );

  errstat_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_flag (
    .clk(clk), .rst_n(rst_n), .clr(clr_any), .hit(err_hit), .flag(err_flag)
  );

  errstat_btn_filter #(.DEB_CYC(DEB_CYC)) u_btn (
    .clk(clk), .rst_n(rst_n), .raw(show_btn_raw), .level(show_held)
  );

  for (genvar k = 0; k < NF; k++) begin : g_range
    localparam logic [CNT_W-1:0] FLOOR = CNT_W'(field_floor(k));
    logic reach;
    assign reach = (err_nxt >= FLOOR);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       range_led[k] <= 1'b0;
      else if (clr_any) range_led[k] <= 1'b0;
      else if (reach)   range_led[k] <= 1'b1;
    end

    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (range_led[k] && !clr_any) |=> range_led[k]);

    a_r5_lit_at_floor: assert property (@(posedge clk) disable iff (!rst_n)
      (err_count >= FLOOR) |-> range_led[k]);
  end

  assign disp_is_cnt = show_held;
  assign disp_val    = show_held ? lead_byte(64'(err_count), NF) : disp_norm;

  a_r7_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    clr_any |=> (err_count == '0 && chk_count == '0 && range_led == '0 && !err_flag));

  a_r8_view_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_is_cnt && err_count != '0) |-> disp_val != 8'h00);

  a_r9_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (!disp_is_cnt) |-> disp_val == disp_norm);

endmodule

// File: tb/errstat_indicator_tb.sv
module errstat_indicator_tb_top;

  localparam int CNT_W = 24;
  localparam int CHK_W = 40;
  localparam int INC_W = 8;
  localparam int HOLD  = 40;
  localparam int DEB   = 8;
  localparam longint ERR_MAX = (longint'(1) << CNT_W) - 1;
  localparam longint CHK_MAX = (longint'(1) << CHK_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [INC_W-1:0] err_inc = '0;
  logic [INC_W-1:0] chk_inc = '0;
  logic             clr_cnt = 1'b0;
  logic             pat_rst = 1'b0;
  logic             btn = 1'b0;
  logic [7:0]       disp_norm = 8'h00;
  logic             err_flag;
  logic [2:0]       range_led;
  logic [7:0]       disp_val;
  logic             disp_is_cnt;
  logic [CNT_W-1:0] err_count;
  logic [CHK_W-1:0] chk_count;

  int n_total = 0;
  int n_bad   = 0;
  bit done    = 0;

  always #10 clk = ~clk;

  errstat_indicator #(
    .CNT_W(CNT_W), .CHK_W(CHK_W), .INC_W(INC_W), .HOLD_CYC(HOLD), .DEB_CYC(DEB)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .err_inc(err_inc), .chk_inc(chk_inc),
    .clr_cnt(clr_cnt), .pat_rst(pat_rst), .show_btn_raw(btn), .disp_norm(disp_norm),
    .err_flag(err_flag), .range_led(range_led), .disp_val(disp_val),
    .disp_is_cnt(disp_is_cnt), .err_count(err_count), .chk_count(chk_count)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_total++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  longint     m_err = 0;
  longint     m_chk = 0;
  int         m_hold = 0;
  logic [2:0] m_led = '0;
  int         m_stab = 1000;
  logic       m_prev_btn = 1'b0;

  always @(posedge clk) begin
    if (btn == m_prev_btn) begin
      if (m_stab < 1000) m_stab++;
    end else begin
      m_stab = 0;
    end
    m_prev_btn = btn;
    if (!rst_n || clr_cnt || pat_rst) begin
      m_err = 0; m_chk = 0; m_hold = 0; m_led = '0;
    end else begin
      if (err_inc != 0) m_hold = HOLD;
      else if (m_hold > 0) m_hold--;
      m_err = m_err + longint'(err_inc);
      if (m_err > ERR_MAX) m_err = ERR_MAX;
      m_chk = m_chk + longint'(chk_inc);
      if (m_chk > CHK_MAX) m_chk = CHK_MAX;
      for (int i = 0; i < 3; i++)
        if (m_err >= (longint'(255) << (8 * i))) m_led[i] = 1'b1;
    end
  end

  function automatic logic [7:0] model_lead(input longint v);
    longint t = v;
    while (t > 255) t = t >> 8;
    return t[7:0];
  endfunction

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      check("R1/R2 err_count", 64'(err_count), 64'(m_err));
      check("R3 chk_count", 64'(chk_count), 64'(m_chk));
      check("R4 err_flag", 64'(err_flag), 64'(m_hold != 0));
      check("R5/R6 range_led", 64'(range_led), 64'(m_led));
      if (m_stab >= DEB + 3) begin
        check("R10 filtered button", 64'(disp_is_cnt), 64'(btn));
        if (btn) check("R8 count view", 64'(disp_val), 64'(model_lead(m_err)));
        else     check("R9 normal view", 64'(disp_val), 64'(disp_norm));
      end
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      n_total++;
      $display("FAIL watchdog: run did not complete");
      $display("  test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
    end
  end

  initial begin
    step(3);
    // R11: reset state
    check("R11 reset err_count", 64'(err_count), 0);
    check("R11 reset leds", 64'(range_led), 0);
    check("R11 reset flag", 64'(err_flag), 0);
    check("R11 reset view", 64'(disp_is_cnt), 0);
    rst_n = 1'b1;
    disp_norm = 8'h3C;
    step(5);

    // R4: flag window and retrigger
    err_inc = 8'd1; chk_inc = 8'd8;
    step(1);
    err_inc = '0; chk_inc = 8'd8;
    check("R4 flag on after error", 64'(err_flag), 1);
    step(20);
    err_inc = 8'd1;
    step(1);
    err_inc = '0;
    step(HOLD - 2);
    check("R4 flag held after retrigger", 64'(err_flag), 1);
    step(5);
    check("R4 flag expired", 64'(err_flag), 0);

    // R5: single steps across 0xFE -> 0xFF
    err_inc = 8'd1;
    step(252);
    check("R1 count before floor", 64'(err_count), 64'h0FE);
    check("R5 led0 still off at 0xFE", 64'(range_led[0]), 0);
    step(1);
    check("R5 led0 lit at 0xFF", 64'(range_led[0]), 1);

    // R6 and R8: climb to 0x2FF, field 0 rolls over
    step(512);
    err_inc = '0;
    check("R1 count 0x2FF", 64'(err_count), 64'h2FF);
    check("R6 led0 sticky after rollover", 64'(range_led[0]), 1);
    btn = 1'b1;
    step(DEB + 6);
    check("R8 leading byte of 0x2FF", 64'(disp_val), 64'h02);
    check("R8 view flag", 64'(disp_is_cnt), 1);
    btn = 1'b0;
    disp_norm = 8'h5A;
    step(DEB + 6);
    check("R9 normal byte back", 64'(disp_val), 64'h5A);

    // R10: short glitch ignored
    btn = 1'b1;
    step(3);
    btn = 1'b0;
    for (int i = 0; i < 15; i++) begin
      check("R10 glitch ignored", 64'(disp_is_cnt), 0);
      step(1);
    end

    // R7: clear beats a same-cycle increment
    clr_cnt = 1'b1; err_inc = 8'd5; chk_inc = 8'd5;
    step(1);
    clr_cnt = 1'b0; err_inc = '0; chk_inc = '0;
    check("R7 count cleared", 64'(err_count), 0);
    check("R7 chk cleared", 64'(chk_count), 0);
    check("R7 leds cleared", 64'(range_led), 0);
    check("R7 flag cleared", 64'(err_flag), 0);
    step(3);

    // R2/R3/R5: large increments up to saturation
    err_inc = 8'd255; chk_inc = 8'd255;
    step(66000);
    check("R2 saturated", 64'(err_count), 64'hFFFFFF);
    check("R5 all lamps lit", 64'(range_led), 64'h7);
    check("R3 chk total", 64'(chk_count), 64'(longint'(66000) * 255));
    btn = 1'b1;
    step(DEB + 6);
    check("R8 leading byte at max", 64'(disp_val), 64'hFF);
    btn = 1'b0;
    step(DEB + 6);

    // R7: pattern reset path
    pat_rst = 1'b1;
    step(1);
    pat_rst = 1'b0; err_inc = '0; chk_inc = '0;
    check("R7 pat_rst clears count", 64'(err_count), 0);
    check("R7 pat_rst clears leds", 64'(range_led), 0);
    check("R7 pat_rst clears flag", 64'(err_flag), 0);
    btn = 1'b1;
    step(DEB + 6);
    check("R8 zero count shows 0x00", 64'(disp_val), 0);
    btn = 1'b0;
    step(DEB + 6);

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end

endmodule